// File: doc/BRIEF.md
# Indirect configuration and port-I/O access bridge

The block sits between a simple host register bus and the request side of a PCI host bridge. Software reaches downstream configuration space and I/O-port space through three host-visible locations: one shared target-address register and two data windows. Software first loads the target address, then reads or writes one of the windows. The window it touches decides whether a configuration cycle or an I/O-port cycle goes downstream. The low offset bits of that access, together with the access size, decide which byte lanes take part.

Writes to a data window are posted. The host access finishes at once, and the downstream request is held until the far side acknowledges it. Reads stall the host through a wait signal until the downstream data comes back. The data is then returned right-justified. A host access to either window while a cycle is still in flight is stalled until that cycle ends. The address register stays writable during that time, and a new address leaves the cycle in flight untouched.

The sequencer has four states. ST_IDLE takes a window access: a write goes to ST_WR_BUSY and a read goes to ST_RD_BUSY. ST_WR_BUSY returns to ST_IDLE on the downstream acknowledge. ST_RD_BUSY moves to ST_RD_RESP on the acknowledge and captures the aligned read data. ST_RD_RESP presents that data to the host with the wait signal low, then returns to ST_IDLE.

Top module: `cfgio_bridge`

## Requirements
- R1: After reset, host_wait and dn_req are low and a read of the address register (host offset 0x064) returns 0.
- R2: A write to offset 0x064 stores all 32 data bits and a read there returns them, with host_wait low. This holds even while a downstream cycle is outstanding, and such a write leaves the address, byte enables and data of the cycle in flight unchanged.
- R3: An access to offset 0x068 starts a configuration cycle (dn_kind = 0). Its dn_addr keeps address-register bits 23:2 (bus 23:16, device/function 15:8, register 7:2), with bits 31:24 and 1:0 forced to zero.
- R4: An access to offset 0x06C starts an I/O-port cycle (dn_kind = 1). Its dn_addr is address-register bits 15:0, zero-extended to 32 bits.
- R5: host_size encodes 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. A byte access drives dn_be = 1 << offset[1:0]. A halfword drives 4'b0011 shifted left by 2*offset[1], with offset bit 0 ignored. A word drives 4'b1111.
- R6: Host write data is right-justified. It is shifted into the selected lanes on dn_wdata, and the bytes of lanes that are not enabled are zero.
- R7: Read data is shifted down from the selected lanes into the low end of host_rdata, and bits above the access size are zero.
- R8: A window write finishes in the cycle it is presented, with host_wait low. dn_req rises on the next clock and holds its fields stable until the clock on which dn_ack is high, then falls.
- R9: A window read holds host_wait high until the downstream acknowledge. On the next cycle it presents the data with host_wait low.
- R10: A window access made while a downstream cycle is outstanding is stalled with host_wait high. Its own cycle starts only after the earlier one has been acknowledged.
- R11: A configuration read acknowledged with dn_abort returns all ones in the access width. An I/O-port read ignores dn_abort and returns the aligned dn_rdata.
- R12: A word read of the configuration window with address-register bits 7:0 zero issues dn_addr[7:0] = 0 with dn_be = 4'b1111, and returns the downstream dword unchanged (the vendor/device ID dword).
- R13: Host accesses to any other offset start no downstream cycle, never wait, leave the address register unchanged and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until host_wait is low |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Host byte offset |
| host_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| host_wdata | input | 32 | Right-justified write data |
| host_rdata | output | 32 | Right-justified read data |
| host_wait | output | 1 | Stall for the current host access |
| dn_req | output | 1 | Downstream cycle request, held until acknowledged |
| dn_kind | output | 1 | 0 = configuration cycle, 1 = I/O-port cycle |
| dn_wr | output | 1 | Downstream write |
| dn_addr | output | 32 | Downstream target address |
| dn_be | output | 4 | Downstream byte enables |
| dn_wdata | output | 32 | Lane-steered write data |
| dn_ack | input | 1 | Downstream cycle complete |
| dn_abort | input | 1 | Cycle ended by master-abort, valid with dn_ack |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
The hardest situation to reach is host traffic that lands while a posted downstream write is still unacknowledged. That traffic is an address rewrite, which must go through without disturbing the held request, and a second window access, which must stall behind it. The bench stretches the response latency of its downstream model to several cycles, so these accesses fall inside the outstanding window. It then compares the fields recorded at each acknowledge with the address that was latched before the rewrite. Master-abort responses and lane steering are reached by having the model answer with a chosen data word and abort flag for each access size and offset.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;
    parameter int BUS_W   = 32;
    parameter int LANES   = BUS_W / 8;
    parameter int LANE_W  = $clog2(LANES);
    parameter int CFG_TOP = 23;
    parameter int PORT_W  = 16;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic {
        KIND_CFG = 1'b0,
        KIND_IO  = 1'b1
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_BUSY,
        ST_RD_BUSY,
        ST_RD_RESP
    } state_e;

    typedef struct packed {
        kind_e              kind;
        logic               wr;
        logic [BUS_W-1:0]   addr;
        logic [LANES-1:0]   be;
        logic [BUS_W-1:0]   wdata;
        logic [LANE_W-1:0]  lane;
        logic [1:0]         size;
    } cyc_t;
endpackage

// File: rtl/cfgio_decode.sv
module cfgio_decode
    import cfgio_pkg::*;
#(
    parameter int                HOST_AW  = 12,
    parameter logic [HOST_AW-1:0] AREG_OFS = 12'h064,
    parameter logic [HOST_AW-1:0] CFG_OFS  = 12'h068,
    parameter logic [HOST_AW-1:0] IO_OFS   = 12'h06C
) (
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic [1:0]         host_size,
    input  logic [BUS_W-1:0]   host_wdata,
    input  logic [BUS_W-1:0]   areg,
    output logic               hit_areg,
    output logic               hit_win,
    output cyc_t               cyc_req
);
    logic                  hit_cfg;
    logic                  hit_io;
    logic [LANE_W-1:0]     lane;
    logic [LANES-1:0]      be;
    logic [1:0]            size_n;
    logic [BUS_W-1:0]      shifted;
    logic [BUS_W-1:0]      steered;
    logic [BUS_W-1:0]      addr_cfg;
    logic [BUS_W-1:0]      addr_io;

    localparam logic [LANES-1:0] ONE_BE  = LANES'(1);
    localparam logic [LANES-1:0] HALF_BE = LANES'(3);

    assign hit_areg = host_addr[HOST_AW-1:LANE_W] == AREG_OFS[HOST_AW-1:LANE_W];
    assign hit_cfg  = host_addr[HOST_AW-1:LANE_W] == CFG_OFS[HOST_AW-1:LANE_W];
    assign hit_io   = host_addr[HOST_AW-1:LANE_W] == IO_OFS[HOST_AW-1:LANE_W];
    assign hit_win  = hit_cfg || hit_io;

    always_comb begin
        unique case (host_size)
            SZ_BYTE: begin
                lane   = host_addr[LANE_W-1:0];
                be     = ONE_BE << lane;
                size_n = SZ_BYTE;
            end
            SZ_HALF: begin
                lane   = host_addr[LANE_W-1:0] & ~LANE_W'(1);
                be     = HALF_BE << lane;
                size_n = SZ_HALF;
            end
            default: begin
                lane   = '0;
                be     = '1;
                size_n = SZ_WORD;
            end
        endcase
    end

    assign shifted = host_wdata << {lane, 3'b000};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign steered[i*8 +: 8] = be[i] ? shifted[i*8 +: 8] : 8'h00;
    end

    always_comb begin
        addr_cfg = '0;
        addr_cfg[CFG_TOP:LANE_W] = areg[CFG_TOP:LANE_W];
        addr_io = '0;
        addr_io[PORT_W-1:0] = areg[PORT_W-1:0];
    end

    always_comb begin
        cyc_req.kind  = hit_io ? KIND_IO : KIND_CFG;
        cyc_req.wr    = host_wr;
        cyc_req.addr  = hit_io ? addr_io : addr_cfg;
        cyc_req.be    = be;
        cyc_req.wdata = steered;
        cyc_req.lane  = lane;
        cyc_req.size  = size_n;
    end
endmodule

// File: rtl/cfgio_rdalign.sv
module cfgio_rdalign
    import cfgio_pkg::*;
(
    input  logic [BUS_W-1:0]  raw,
    input  logic [LANE_W-1:0] lane,
    input  logic [1:0]        size,
    input  kind_e             kind,
    input  logic              abort,
    output logic [BUS_W-1:0]  aligned
);
    logic [BUS_W-1:0] shifted;
    logic [BUS_W-1:0] mask;

    assign shifted = raw >> {lane, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: mask = BUS_W'(8'hFF);
            SZ_HALF: mask = BUS_W'(16'hFFFF);
            default: mask = '1;
        endcase
    end

    assign aligned = (abort && kind == KIND_CFG) ? mask : (shifted & mask);
endmodule

// File: rtl/cfgio_seq.sv
module cfgio_seq
    import cfgio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             hit_win,
    input  cyc_t             cyc_req,
    input  logic             dn_ack,
    input  logic [BUS_W-1:0] rd_aligned,
    output logic             host_wait,
    output logic             dn_req,
    output cyc_t             cyc_q,
    output logic [BUS_W-1:0] rd_q,
    output logic             in_resp
);
    state_e state_q;
    state_e state_d;
    logic   launch;
    logic   capture;
    logic   win_req;

    assign win_req = host_req && hit_win;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        launch    = 1'b0;
        capture   = 1'b0;
        host_wait = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (win_req) begin
                    launch = 1'b1;
                    if (cyc_req.wr) begin
                        state_d = ST_WR_BUSY;
                    end else begin
                        state_d   = ST_RD_BUSY;
                        host_wait = 1'b1;
                    end
                end
            end
            ST_WR_BUSY: begin
                host_wait = win_req;
                if (dn_ack) state_d = ST_IDLE;
            end
            ST_RD_BUSY: begin
                host_wait = win_req;
                if (dn_ack) begin
                    capture = 1'b1;
                    state_d = ST_RD_RESP;
                end
            end
            ST_RD_RESP: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_req <= 1'b0;
            cyc_q  <= '0;
            rd_q   <= '0;
        end else begin
            if (launch) begin
                dn_req <= 1'b1;
                cyc_q  <= cyc_req;
            end else if (dn_ack) begin
                dn_req <= 1'b0;
            end
            if (capture) rd_q <= rd_aligned;
        end
    end

    assign in_resp = state_q == ST_RD_RESP;
endmodule

// File: rtl/cfgio_bridge.sv
module cfgio_bridge
    import cfgio_pkg::*;
#(
    parameter int                 HOST_AW  = 12,
    parameter logic [HOST_AW-1:0] AREG_OFS = 12'h064,
    parameter logic [HOST_AW-1:0] CFG_OFS  = 12'h068,
    parameter logic [HOST_AW-1:0] IO_OFS   = 12'h06C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [1:0]         host_size,
    input  logic [BUS_W-1:0]   host_wdata,
    output logic [BUS_W-1:0]   host_rdata,
    output logic               host_wait,
    output logic               dn_req,
    output logic               dn_kind,
    output logic               dn_wr,
    output logic [BUS_W-1:0]   dn_addr,
    output logic [LANES-1:0]   dn_be,
    output logic [BUS_W-1:0]   dn_wdata,
    input  logic               dn_ack,
    input  logic               dn_abort,
    input  logic [BUS_W-1:0]   dn_rdata
);
    logic [BUS_W-1:0] areg;
    logic             hit_areg;
    logic             hit_win;
    cyc_t             cyc_req;
    cyc_t             cyc_q;
    logic [BUS_W-1:0] rd_aligned;
    logic [BUS_W-1:0] rd_q;
    logic             in_resp;

    cfgio_decode #(
        .HOST_AW  (HOST_AW),
        .AREG_OFS (AREG_OFS),
        .CFG_OFS  (CFG_OFS),
        .IO_OFS   (IO_OFS)
    ) u_decode (
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_size  (host_size),
        .host_wdata (host_wdata),
        .areg       (areg),
        .hit_areg   (hit_areg),
        .hit_win    (hit_win),
        .cyc_req    (cyc_req)
    );

    cfgio_rdalign u_rdalign (
        .raw     (dn_rdata),
        .lane    (cyc_q.lane),
        .size    (cyc_q.size),
        .kind    (cyc_q.kind),
        .abort   (dn_abort),
        .aligned (rd_aligned)
    );

    cfgio_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .hit_win    (hit_win),
        .cyc_req    (cyc_req),
        .dn_ack     (dn_ack),
        .rd_aligned (rd_aligned),
        .host_wait  (host_wait),
        .dn_req     (dn_req),
        .cyc_q      (cyc_q),
        .rd_q       (rd_q),
        .in_resp    (in_resp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                             areg <= '0;
        else if (host_req && host_wr && hit_areg) areg <= host_wdata;
    end

    assign host_rdata = in_resp  ? rd_q :
                        hit_areg ? areg : '0;

    assign dn_kind  = cyc_q.kind;
    assign dn_wr    = cyc_q.wr;
    assign dn_addr  = cyc_q.addr;
    assign dn_be    = cyc_q.be;
    assign dn_wdata = cyc_q.wdata;
endmodule

// File: rtl/cfgio_bridge_chk.sv
module cfgio_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_req,
    input logic        host_wait,
    input logic        dn_req,
    input logic        dn_kind,
    input logic        dn_wr,
    input logic [31:0] dn_addr,
    input logic [3:0]  dn_be,
    input logic [31:0] dn_wdata,
    input logic        dn_ack
);
    logic [31:0] be_mask;
    assign be_mask = {{8{dn_be[3]}}, {8{dn_be[2]}}, {8{dn_be[1]}}, {8{dn_be[0]}}};

    // R8 and R2: fields of an outstanding cycle stay put
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_be)
                              && $stable(dn_kind) && $stable(dn_wr) && $stable(dn_wdata));

    assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_ack |=> !dn_req);

    assert_be_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> ($countones(dn_be) == 1 || dn_be == 4'b0011
                    || dn_be == 4'b1100 || dn_be == 4'b1111));

    assert_cfg_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_kind |-> dn_addr[1:0] == 2'b00 && dn_addr[31:24] == 8'h00);

    assert_io_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_kind |-> dn_addr[31:16] == 16'h0000);

    assert_lane_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_wr |-> (dn_wdata & ~be_mask) == 32'h0);

    assert_wait_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_wait |-> host_req);
endmodule

bind cfgio_bridge cfgio_bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (host_req),
    .host_wait (host_wait),
    .dn_req    (dn_req),
    .dn_kind   (dn_kind),
    .dn_wr     (dn_wr),
    .dn_addr   (dn_addr),
    .dn_be     (dn_be),
    .dn_wdata  (dn_wdata),
    .dn_ack    (dn_ack)
);

// File: tb/cfgio_bridge_tb.sv
`timescale 1ns/1ps
module cfgio_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [11:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_wait;
    logic        dn_req;
    logic        dn_kind;
    logic        dn_wr;
    logic [31:0] dn_addr;
    logic [3:0]  dn_be;
    logic [31:0] dn_wdata;
    logic        dn_ack = 1'b0;
    logic        dn_abort = 1'b0;
    logic [31:0] dn_rdata = '0;

    int checks = 0;
    int errors = 0;

    int          dn_lat = 0;
    logic [31:0] resp_data = '0;
    logic        resp_abort = 1'b0;
    int          dn_count = 0;
    logic        rec_kind [16];
    logic        rec_wr   [16];
    logic [31:0] rec_addr [16];
    logic [3:0]  rec_be   [16];
    logic [31:0] rec_wdata[16];

    always #2.5 clk = ~clk;

    cfgio_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_wait(host_wait), .dn_req(dn_req),
        .dn_kind(dn_kind), .dn_wr(dn_wr), .dn_addr(dn_addr), .dn_be(dn_be),
        .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_abort(dn_abort), .dn_rdata(dn_rdata)
    );

    // downstream target model
    initial begin
        int wcnt;
        wcnt = 0;
        forever begin
            @(negedge clk);
            dn_ack = 1'b0;
            dn_abort = 1'b0;
            if (dn_req && rst_n) begin
                if (wcnt >= dn_lat) begin
                    rec_kind[dn_count % 16]  = dn_kind;
                    rec_wr[dn_count % 16]    = dn_wr;
                    rec_addr[dn_count % 16]  = dn_addr;
                    rec_be[dn_count % 16]    = dn_be;
                    rec_wdata[dn_count % 16] = dn_wdata;
                    dn_count++;
                    dn_ack   = 1'b1;
                    dn_abort = resp_abort;
                    dn_rdata = resp_data;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic host_access(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                               input logic [31:0] wd, output logic [31:0] rd, output int waits);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_size = sz; host_wdata = wd;
        waits = 0;
        #1;
        while (host_wait) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd = host_rdata;
        @(posedge clk);
        #1;
        host_req = 1'b0;
    endtask

    task automatic wait_dn(input int n);
        while (dn_count < n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] rd; int w;
        chk_eq("R1 host_wait", {31'b0, host_wait}, 32'h0);
        chk_eq("R1 dn_req", {31'b0, dn_req}, 32'h0);
        host_access(1'b0, 12'h064, 2'd2, '0, rd, w);
        chk_eq("R1 areg reset", rd, 32'h0);
    endtask

    task automatic t_addr_reg;
        logic [31:0] rd; int w;
        host_access(1'b1, 12'h064, 2'd2, 32'hF00D_1234, rd, w);
        chk_eq("R2 write no wait", w, 0);
        host_access(1'b0, 12'h064, 2'd2, '0, rd, w);
        chk_eq("R2 readback", rd, 32'hF00D_1234);
    endtask

    task automatic t_cfg_word;
        logic [31:0] rd; int w; int n;
        host_access(1'b1, 12'h064, 2'd2, 32'h8012_3457, rd, w);
        dn_lat = 1; resp_data = 32'hDEAD_BEEF; resp_abort = 1'b0;
        n = dn_count;
        host_access(1'b0, 12'h068, 2'd2, '0, rd, w);
        wait_dn(n + 1);
        chk_eq("R3 cfg kind", {31'b0, rec_kind[n % 16]}, 32'h0);
        chk_eq("R3 cfg addr", rec_addr[n % 16], 32'h0012_3454);
        chk_eq("R5 word be", {28'b0, rec_be[n % 16]}, 32'hF);
        chk_eq("R9 read data", rd, 32'hDEAD_BEEF);
        chk(w > 0, "R9 read waited", w, 1);
    endtask

    task automatic t_vendor_id;
        logic [31:0] rd; int w; int n;
        host_access(1'b1, 12'h064, 2'd2, 32'h0003_0800, rd, w);
        resp_data = 32'h1234_10EC; dn_lat = 0;
        n = dn_count;
        host_access(1'b0, 12'h068, 2'd2, '0, rd, w);
        wait_dn(n + 1);
        chk_eq("R12 addr low byte", {24'b0, rec_addr[n % 16][7:0]}, 32'h0);
        chk_eq("R12 be", {28'b0, rec_be[n % 16]}, 32'hF);
        chk_eq("R12 id dword", rd, 32'h1234_10EC);
    endtask

    task automatic t_io_bytes;
        logic [31:0] rd; int w; int n;
        host_access(1'b1, 12'h064, 2'd2, 32'hABCD_03F9, rd, w);
        n = dn_count;
        host_access(1'b1, 12'h06E, 2'd0, 32'h0000_005A, rd, w);
        wait_dn(n + 1);
        chk_eq("R4 io kind", {31'b0, rec_kind[n % 16]}, 32'h1);
        chk_eq("R4 io addr", rec_addr[n % 16], 32'h0000_03F9);
        chk_eq("R5 byte be lane2", {28'b0, rec_be[n % 16]}, 32'h4);
        chk_eq("R6 byte steer", rec_wdata[n % 16], 32'h005A_0000);
        resp_data = 32'hA1B2_C3D4;
        host_access(1'b0, 12'h06D, 2'd0, '0, rd, w);
        wait_dn(n + 2);
        chk_eq("R5 byte be lane1", {28'b0, rec_be[(n + 1) % 16]}, 32'h2);
        chk_eq("R7 byte read", rd, 32'h0000_00C3);
    endtask

    task automatic t_halves;
        logic [31:0] rd; int w; int n;
        host_access(1'b1, 12'h064, 2'd2, 32'h0001_0010, rd, w);
        resp_data = 32'hA1B2_C3D4;
        n = dn_count;
        host_access(1'b0, 12'h06B, 2'd1, '0, rd, w);
        wait_dn(n + 1);
        chk_eq("R5 half be upper", {28'b0, rec_be[n % 16]}, 32'hC);
        chk_eq("R7 half read", rd, 32'h0000_A1B2);
        host_access(1'b1, 12'h068, 2'd1, 32'hFFFF_1234, rd, w);
        wait_dn(n + 2);
        chk_eq("R5 half be lower", {28'b0, rec_be[(n + 1) % 16]}, 32'h3);
        chk_eq("R6 half steer", rec_wdata[(n + 1) % 16], 32'h0000_1234);
        host_access(1'b1, 12'h06C, 2'd3, 32'h8765_4321, rd, w);
        wait_dn(n + 3);
        chk_eq("R5 size3 be", {28'b0, rec_be[(n + 2) % 16]}, 32'hF);
        chk_eq("R6 word data", rec_wdata[(n + 2) % 16], 32'h8765_4321);
    endtask

    task automatic t_abort;
        logic [31:0] rd; int w; int n;
        n = dn_count;
        resp_abort = 1'b1; resp_data = 32'h1357_9BDF;
        host_access(1'b0, 12'h069, 2'd0, '0, rd, w);
        chk_eq("R11 cfg byte abort", rd, 32'h0000_00FF);
        host_access(1'b0, 12'h068, 2'd2, '0, rd, w);
        chk_eq("R11 cfg word abort", rd, 32'hFFFF_FFFF);
        host_access(1'b0, 12'h06C, 2'd2, '0, rd, w);
        chk_eq("R11 io abort passes data", rd, 32'h1357_9BDF);
        wait_dn(n + 3);
        resp_abort = 1'b0;
    endtask

    task automatic t_posted;
        logic [31:0] rd; int w; int n;
        host_access(1'b1, 12'h064, 2'd2, 32'h0000_1111, rd, w);
        dn_lat = 5;
        n = dn_count;
        host_access(1'b1, 12'h06C, 2'd2, 32'hCAFE_F00D, rd, w);
        chk_eq("R8 posted no wait", w, 0);
        chk_eq("R8 dn_req raised", {31'b0, dn_req}, 32'h1);
        host_access(1'b1, 12'h064, 2'd2, 32'h0000_2222, rd, w);
        chk_eq("R2 areg write while busy no wait", w, 0);
        chk_eq("R8 dn_req still held", {31'b0, dn_req}, 32'h1);
        wait_dn(n + 1);
        chk_eq("R2 in-flight addr kept", rec_addr[n % 16], 32'h0000_1111);
        chk_eq("R8 in-flight data kept", rec_wdata[n % 16], 32'hCAFE_F00D);
        chk_eq("R8 dn_req dropped", {31'b0, dn_req}, 32'h0);
        host_access(1'b0, 12'h064, 2'd2, '0, rd, w);
        chk_eq("R2 new addr latched", rd, 32'h0000_2222);
    endtask

    task automatic t_stall;
        logic [31:0] rd; int w; int n;
        dn_lat = 3; resp_data = 32'h0BAD_CAFE;
        n = dn_count;
        host_access(1'b1, 12'h06C, 2'd2, 32'h5555_AAAA, rd, w);
        host_access(1'b0, 12'h06C, 2'd2, '0, rd, w);
        chk(w > 4, "R10 read stalled behind write", w, 5);
        chk_eq("R10 both cycles issued", dn_count - n, 2);
        chk_eq("R10 first was write", {31'b0, rec_wr[n % 16]}, 32'h1);
        chk_eq("R10 second was read", {31'b0, rec_wr[(n + 1) % 16]}, 32'h0);
        chk_eq("R10 read data", rd, 32'h0BAD_CAFE);
        dn_lat = 0;
    endtask

    task automatic t_ignored;
        logic [31:0] rd; int w; int n;
        host_access(1'b1, 12'h064, 2'd2, 32'h0000_3333, rd, w);
        n = dn_count;
        host_access(1'b1, 12'h070, 2'd2, 32'h7777_7777, rd, w);
        chk_eq("R13 other write no wait", w, 0);
        repeat (4) @(negedge clk);
        chk_eq("R13 no downstream cycle", dn_count - n, 0);
        chk_eq("R13 dn_req low", {31'b0, dn_req}, 32'h0);
        host_access(1'b0, 12'h070, 2'd2, '0, rd, w);
        chk_eq("R13 other read zero", rd, 32'h0);
        host_access(1'b0, 12'h064, 2'd2, '0, rd, w);
        chk_eq("R13 areg unchanged", rd, 32'h0000_3333);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_reg();
        t_cfg_word();
        t_vendor_id();
        t_io_bytes();
        t_halves();
        t_abort();
        t_posted();
        t_stall();
        t_ignored();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule